// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a memory slave that tags transfers with transaction IDs. It pairs exclusive reads with the exclusive writes that follow them. When an exclusive read is accepted, the monitor stores a reservation for the read's ID. A reservation is a valid flag plus the address granule. Each ID holds at most one reservation, so a newer exclusive read from the same ID replaces the older one, whether or not the older one was ever used.

Every write the slave commits is presented to the monitor in the cycle it takes effect. A plain write always goes through. An exclusive write goes through only if its own ID still holds a valid reservation on the same granule. The monitor drives a combinational write-enable gate toward the memory array. One cycle later it returns a write response: EXOKAY for a successful exclusive write, and OKAY for every other write. A write that reaches memory clears every reservation on its granule, whichever ID owns that reservation.

Top module: `excl_monitor`

## Requirements
- R1: A cycle with `rd_valid` and `rd_excl` high stores a valid reservation for `rd_id` at the granule of `rd_addr`.
- R2: A later exclusive read with the same ID replaces that ID's granule, so an exclusive write to the old granule fails and one to the new granule succeeds.
- R3: An exclusive write whose ID holds a valid reservation on the write's granule raises `mem_we` in the same cycle and returns `wr_resp` = 2'b01 (EXOKAY) one cycle later.
- R4: An exclusive write whose ID holds no valid reservation on the write's granule keeps `mem_we` low and returns `wr_resp` = 2'b00 (OKAY).
- R5: Any write that raises `mem_we`, plain or exclusive, invalidates every reservation on that granule for all IDs, including the writer's own.
- R6: A failed exclusive write invalidates no reservation.
- R7: If an exclusive read and a committed write to the same granule occur in the same cycle, the clearing is applied first and the new reservation remains valid.
- R8: A plain write (`wr_excl` low) always raises `mem_we` and returns OKAY.
- R9: Reset invalidates all reservations and holds `mem_we` and `wr_resp_valid` low.
- R10: Addresses are compared only on the bits at and above `GRAN_LSB`. Addresses in the same 2**GRAN_LSB-byte granule match, and addresses in neighbouring granules do not.
- R11: `wr_resp_valid` is high exactly in the cycle after a cycle with `wr_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | A read address is accepted this cycle |
| rd_excl | input | 1 | The accepted read is exclusive |
| rd_id | input | ID_W | Transaction ID of the read |
| rd_addr | input | ADDR_W | Byte address of the read |
| wr_valid | input | 1 | A write takes its decision this cycle |
| wr_excl | input | 1 | The write is exclusive |
| wr_id | input | ID_W | Transaction ID of the write |
| wr_addr | input | ADDR_W | Byte address of the write |
| mem_we | output | 1 | Write enable toward the memory array |
| wr_resp_valid | output | 1 | Write response is valid |
| wr_resp | output | 2 | 2'b00 OKAY, 2'b01 EXOKAY |

## Verification
The bench builds the monitor with ID_W = 2, which gives four reservation entries, with ADDR_W = 16 and GRAN_LSB = 3, which gives 8-byte granules. Four IDs are enough to hold reservations from two IDs on one granule, so a single plain write can be seen clearing both of them. Eight-byte granules put offsets 0x04 and 0x08 within easy reach. The first must match a reservation at 0x00 and the second must not, which checks both sides of the comparison boundary.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ID_W     = 2,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_excl,
  input  logic [ID_W-1:0]   rd_id,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_valid,
  input  logic              wr_excl,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              mem_we,
  output logic              wr_resp_valid,
  output logic [1:0]        wr_resp
);
  localparam int N    = 1 << ID_W;
  localparam int GW   = ADDR_W - GRAN_LSB;
  localparam logic [1:0] OKAY   = 2'b00;
  localparam logic [1:0] EXOKAY = 2'b01;

  logic [N-1:0]  res_vld;
  logic [GW-1:0] res_gran [N];

  logic [GW-1:0] wr_gran, rd_gran;
  logic          excl_hit;

  assign wr_gran  = wr_addr[ADDR_W-1:GRAN_LSB];
  assign rd_gran  = rd_addr[ADDR_W-1:GRAN_LSB];
  assign excl_hit = res_vld[wr_id] && (res_gran[wr_id] == wr_gran);
  assign mem_we   = wr_valid && (!wr_excl || excl_hit);

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic snoop_clr, take;
    assign snoop_clr = mem_we && (res_gran[i] == wr_gran);
    assign take      = rd_valid && rd_excl && (rd_id == ID_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_vld[i]  <= 1'b0;
        res_gran[i] <= '0;
      end else if (take) begin
        res_vld[i]  <= 1'b1;
        res_gran[i] <= rd_gran;
      end else if (snoop_clr) begin
        res_vld[i]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_resp_valid <= 1'b0;
      wr_resp       <= OKAY;
    end else begin
      wr_resp_valid <= wr_valid;
      wr_resp       <= (wr_valid && wr_excl && excl_hit) ? EXOKAY : OKAY;
    end
  end
endmodule

module excl_monitor_chk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_excl,
  input logic              mem_we,
  input logic              wr_resp_valid,
  input logic [1:0]        wr_resp
);
  a_r8_plain_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_excl) |-> mem_we);
  a_r9_no_gate_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !mem_we);
  a_r3_exokay_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_excl && mem_we) |=> (wr_resp_valid && wr_resp == 2'b01));
  a_r4_okay_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !(wr_excl && mem_we)) |=> (wr_resp_valid && wr_resp == 2'b00));
  a_r11_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !wr_resp_valid);
endmodule

bind excl_monitor excl_monitor_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_excl(wr_excl),
  .mem_we(mem_we), .wr_resp_valid(wr_resp_valid), .wr_resp(wr_resp)
);

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 2, ADDR_W = 16, GRAN_LSB = 3;

  logic clk = 0, rst_n = 0;
  logic rd_valid = 0, rd_excl = 0, wr_valid = 0, wr_excl = 0;
  logic [ID_W-1:0] rd_id = '0, wr_id = '0;
  logic [ADDR_W-1:0] rd_addr = '0, wr_addr = '0;
  logic mem_we, wr_resp_valid;
  logic [1:0] wr_resp;

  int checks = 0, fails = 0;
  logic [1:0] exp_q [$];
  string tag_q [$];

  excl_monitor #(.ID_W(ID_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_excl_monitor (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_excl(rd_excl), .rd_id(rd_id),
    .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_excl(wr_excl), .wr_id(wr_id),
    .wr_addr(wr_addr), .mem_we(mem_we), .wr_resp_valid(wr_resp_valid), .wr_resp(wr_resp));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    rd_valid = 0; rd_excl = 0; wr_valid = 0; wr_excl = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      clear_all();
    end
  endtask

  task automatic set_rd(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a);
    rd_valid = 1; rd_excl = 1; rd_id = id; rd_addr = a;
  endtask

  task automatic set_wr(input bit ex, input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                        input bit exp_we, input string tag);
    wr_valid = 1; wr_excl = ex; wr_id = id; wr_addr = a;
    #1;
    check(mem_we == exp_we, tag, mem_we, exp_we);
    exp_q.push_back((ex && exp_we) ? 2'b01 : 2'b00);
    tag_q.push_back(tag);
  endtask

  task automatic do_rd(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a);
    @(negedge clk); clear_all(); set_rd(id, a);
  endtask

  task automatic do_wr(input bit ex, input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                       input bit exp_we, input string tag);
    @(negedge clk); clear_all(); set_wr(ex, id, a, exp_we, tag);
  endtask

  // monitor: pops the scoreboard as responses appear (R11)
  always @(posedge clk) begin
    #1;
    if (rst_n && wr_resp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R11 unexpected response", 1, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(wr_resp == e, t, wr_resp, e);
      end
    end else if (rst_n && exp_q.size() != 0) begin
      check(0, "R11 missing response", 0, 1);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(mem_we == 0 && wr_resp_valid == 0, "R9 reset outputs", {mem_we, wr_resp_valid}, 0);
    rst_n = 1;
    do_wr(1, 0, 16'h0000, 0, "R9 no reservation after reset");
    do_rd(1, 16'h0100);
    do_wr(1, 1, 16'h0104, 1, "R1 R3 R10 reserved granule succeeds");
    do_wr(1, 1, 16'h0100, 0, "R5 own success clears reservation");
    do_rd(0, 16'h0200);
    do_rd(0, 16'h0300);
    do_wr(1, 0, 16'h0200, 0, "R2 R4 replaced granule fails");
    do_wr(1, 0, 16'h0300, 1, "R2 new granule succeeds");
    do_rd(2, 16'h0400);
    do_rd(3, 16'h0400);
    do_wr(0, 0, 16'h0404, 1, "R8 plain write passes");
    do_wr(1, 2, 16'h0400, 0, "R5 plain write cleared id2");
    do_wr(1, 3, 16'h0400, 0, "R5 plain write cleared id3");
    do_rd(1, 16'h0500);
    do_wr(1, 2, 16'h0500, 0, "R4 other id has no reservation");
    do_wr(1, 1, 16'h0500, 1, "R6 failed write cleared nothing");
    @(negedge clk); clear_all(); set_rd(0, 16'h0600);
    set_wr(0, 1, 16'h0600, 1, "R7 R8 plain write same cycle as read");
    do_wr(1, 0, 16'h0600, 1, "R7 same-cycle reservation kept");
    do_rd(2, 16'h0700);
    do_wr(0, 3, 16'h0708, 1, "R8 plain write next granule");
    do_wr(1, 2, 16'h0700, 1, "R10 neighbouring granule not cleared");
    do_rd(3, 16'h0800);
    idle(3);
    check(exp_q.size() == 0, "R11 all responses returned", exp_q.size(), 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(mem_we == 0 && wr_resp_valid == 0, "R9 reset outputs mid-run", {mem_we, wr_resp_valid}, 0);
    rst_n = 1;
    do_wr(1, 3, 16'h0800, 0, "R9 reset cleared reservation");
    idle(3);
    check(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule